// File: doc/BRIEF.md
# Streaming Reflected CRC-32 Engine

This block computes a 32-bit cyclic redundancy checksum over a byte stream. Each clock it can take a beat of up to four bytes together with a byte count, so a message of any length can be fed. Whole beats move four bytes in one step. A short final beat moves only the bytes it carries. Two generator polynomials are offered: the Ethernet/zip polynomial and the Castagnoli polynomial. Both are used in reflected form, so the low bit of each byte goes in first.

A caller pulses `start_i` with a seed and a polynomial select, then streams beats. It flags the final beat with `in_last_i`. One cycle later the finished checksum appears on `crc_o` with a one-cycle `done_o` strobe. A zero seed gives a fresh checksum. A seed equal to an earlier finished checksum continues that computation, so the checksum of a long message can be built from its pieces.

Top module: `crc32_stream`

## Requirements
- R1: While reset is held and after it is released, `in_ready_o` and `done_o` are 0 and `crc_o` is 0x00000000.
- R2: A `start_i` pulse makes `in_ready_o` 1 from the next cycle. The seed is inverted into the running state. `poly_sel_i` is latched: 0 selects reflected polynomial 0xEDB88320, and 1 selects 0x82F63B78. `start_i` takes priority over a beat in the same cycle.
- R3: With select 0 and seed 0, the bytes 0x48, 0x69, 0x0A give 0xD5223C9A. Sending them as one beat gives the same value as sending them as three one-byte beats.
- R4: With select 1 and seed 0, the ASCII digits "123456789" give 0xE3069283. With select 0 they give 0xCBF43926.
- R5: Within a beat, byte k sits on `in_data_i[8k+7:8k]`, and byte 0 is earliest in the stream. A count n of 1 to 4 absorbs bytes 0 to n-1 only. The higher bytes have no effect, and the bits of each byte are absorbed starting with bit 0.
- R6: The result depends only on the byte sequence, the seed and the polynomial. It does not depend on how the bytes are split into beats of one to four bytes.
- R7: Seeding with the finished result of message s and then feeding message t gives the same value as hashing s followed by t from seed 0.
- R8: Adding a leading zero byte to a message changes its result.
- R9: A beat with count 0 absorbs nothing. Start with seed 0 followed at once by a count-0 last beat gives 0x00000000.
- R10: Accepting a last beat makes `done_o` 1 for exactly the next cycle, with the result on `crc_o`. `in_ready_o` is then 0 until the next start. `crc_o` holds its value until the next finished message.
- R11: A beat is taken only when `in_valid_i` and `in_ready_o` are both 1. Cycles with `in_valid_i` low, and beats offered while not ready, change neither the state nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a message: load seed and polynomial select |
| seed_i | input | 32 | Zero, or an earlier finished checksum to continue from |
| poly_sel_i | input | 1 | 0: 0xEDB88320, 1: 0x82F63B78 (reflected) |
| in_valid_i | input | 1 | Beat offered |
| in_ready_o | output | 1 | Engine accepts beats |
| in_data_i | input | 32 | Beat bytes, byte 0 in the low lane |
| in_count_i | input | 3 | Bytes used in this beat (0 to 4) |
| in_last_i | input | 1 | This beat ends the message |
| done_o | output | 1 | One-cycle strobe: result ready |
| crc_o | output | 32 | Finished checksum |

## Verification
`in_ready_o` rises on the clock edge that samples `start_i`. `crc_o` and `done_o` change on the edge that accepts the last beat. Both are therefore due one cycle after the stimulus. The bench drives every input on falling edges and samples on the next falling edge after the accepting rising edge. That is the first point where the registered values are visible and the strobe has not yet cleared. Idle cycles and junk upper lanes are mixed in between beats. Checks on held values are made in the cycle after the strobe.

// File: rtl/crc32_pkg.sv
// crc32_pkg: shared constants and types for the streaming checksum engine.
// Assumes a 32-bit reflected checksum. Lane count sets the bytes per beat.
package crc32_pkg;
    localparam int CRC_W   = 32;
    localparam int BYTE_W  = 8;
    localparam int LANES   = 4;
    localparam int CNT_W   = $clog2(LANES + 1);

    localparam logic [CRC_W-1:0] POLY_IEEE       = 32'hEDB88320;
    localparam logic [CRC_W-1:0] POLY_CASTAGNOLI = 32'h82F63B78;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_t;
endpackage

// File: rtl/crc32_byte_step.sv
// crc32_byte_step: absorbs one byte into a reflected CRC state, bit 0 first.
// Purely combinational. Gives the same value as the 256-entry table update
// without needing a table.
module crc32_byte_step
    import crc32_pkg::*;
(
    input  logic [CRC_W-1:0]  state_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [CRC_W-1:0]  poly_i,
    output logic [CRC_W-1:0]  state_o
);
    // Eight shift/conditional-xor steps after folding the byte into the low lane.
    always_comb begin
        logic [CRC_W-1:0] s;
        s = state_i ^ {{(CRC_W-BYTE_W){1'b0}}, byte_i};
        for (int b = 0; b < BYTE_W; b++) begin
            s = s[0] ? ((s >> 1) ^ poly_i) : (s >> 1);
        end
        state_o = s;
    end
endmodule

// File: rtl/crc32_slice.sv
// crc32_slice: absorbs 0..LANES bytes of one beat in a single cycle.
// A chain of byte steps runs from lane 0 upward. The count picks the tap of
// the chain, so a short tail beat is absorbed byte by byte. Counts above
// LANES are treated as LANES.
module crc32_slice
    import crc32_pkg::*;
#(
    parameter int NLANE = LANES,
    localparam int CW   = $clog2(NLANE + 1)
)(
    input  logic [CRC_W-1:0]        state_i,
    input  logic [NLANE*BYTE_W-1:0] data_i,
    input  logic [CW-1:0]           count_i,
    input  logic [CRC_W-1:0]        poly_i,
    output logic [CRC_W-1:0]        state_o
);
    logic [CRC_W-1:0] chain [0:NLANE];

    assign chain[0] = state_i;

    genvar k;
    generate
        for (k = 0; k < NLANE; k++) begin : g_lane
            crc32_byte_step u_step (
                .state_i (chain[k]),
                .byte_i  (data_i[k*BYTE_W +: BYTE_W]),
                .poly_i  (poly_i),
                .state_o (chain[k+1])
            );
        end
    endgenerate

    // Pick the chain tap after the last byte in use.
    always_comb begin
        state_o = chain[0];
        for (int n = 1; n <= NLANE; n++) begin
            if (int'(count_i) >= n) state_o = chain[n];
        end
    end
endmodule

// File: rtl/crc32_stream.sv
// crc32_stream: top of the streaming reflected CRC-32 engine.
// Start loads the inverted seed and latches the polynomial. Beats are taken
// while running. The last beat registers the inverted state as the result,
// with a one-cycle done strobe. The engine then idles until the next start.
module crc32_stream
    import crc32_pkg::*;
#(
    parameter int NLANE = LANES,
    localparam int CW   = $clog2(NLANE + 1)
)(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [CRC_W-1:0]        seed_i,
    input  logic                    poly_sel_i,
    input  logic                    in_valid_i,
    output logic                    in_ready_o,
    input  logic [NLANE*BYTE_W-1:0] in_data_i,
    input  logic [CW-1:0]           in_count_i,
    input  logic                    in_last_i,
    output logic                    done_o,
    output logic [CRC_W-1:0]        crc_o
);
    phase_t           phase_q;
    logic [CRC_W-1:0] state_q;
    logic [CRC_W-1:0] poly_q;
    logic [CRC_W-1:0] state_next;
    logic             beat_fire;

    assign in_ready_o = (phase_q == PH_RUN);
    assign beat_fire  = in_valid_i && in_ready_o && !start_i;

    crc32_slice #(.NLANE(NLANE)) u_slice (
        .state_i (state_q),
        .data_i  (in_data_i),
        .count_i (in_count_i),
        .poly_i  (poly_q),
        .state_o (state_next)
    );

    // Phase, running state, latched polynomial, result and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            state_q <= '1;
            poly_q  <= POLY_IEEE;
            crc_o   <= '0;
            done_o  <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (start_i) begin
                phase_q <= PH_RUN;
                state_q <= ~seed_i;
                poly_q  <= poly_sel_i ? POLY_CASTAGNOLI : POLY_IEEE;
            end else if (beat_fire) begin
                state_q <= state_next;
                if (in_last_i) begin
                    crc_o   <= ~state_next;
                    done_o  <= 1'b1;
                    phase_q <= PH_IDLE;
                end
            end
        end
    end
endmodule

// File: rtl/crc32_stream_chk.sv
// crc32_stream_chk: protocol checks on the engine's ports, bound to the top.
module crc32_stream_chk
    import crc32_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             in_valid_i,
    input logic             in_last_i,
    input logic             in_ready_o,
    input logic             done_o,
    input logic [CRC_W-1:0] crc_o
);
    // R2: start opens the input on the next cycle.
    a_r2_start_ready: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> in_ready_o);

    // R10: the strobe lasts a single cycle.
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: after a finish the input stays closed until a start.
    a_r10_closed_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> !in_ready_o);

    // R10: the result holds unless a message finishes.
    a_r10_crc_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(crc_o));

    // R11: a strobe only follows an accepted last beat.
    a_r11_done_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(in_valid_i && in_ready_o && in_last_i && !start_i));
endmodule

bind crc32_stream crc32_stream_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .in_valid_i (in_valid_i),
    .in_last_i  (in_last_i),
    .in_ready_o (in_ready_o),
    .done_o     (done_o),
    .crc_o      (crc_o)
);

// File: tb/tb_crc32_stream.sv
// tb_crc32_stream: directed and seeded-random checks against a bench model.
module tb_crc32_stream;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] seed_i = '0;
    logic        poly_sel_i = 1'b0;
    logic        in_valid_i = 1'b0;
    logic        in_ready_o;
    logic [31:0] in_data_i = '0;
    logic [2:0]  in_count_i = '0;
    logic        in_last_i = 1'b0;
    logic        done_o;
    logic [31:0] crc_o;

    int checks = 0;
    int fails  = 0;
    logic [7:0] msg [0:127];

    always #4 clk = ~clk;

    crc32_stream dut (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Bench model: bit-serial reflected CRC over msg[off +: n].
    function automatic logic [31:0] ref_crc(input logic [31:0] seed, input bit sel, input int off, input int n);
        logic [31:0] p = sel ? 32'h82F63B78 : 32'hEDB88320;
        logic [31:0] s = ~seed;
        for (int i = 0; i < n; i++) begin
            s ^= {24'h0, msg[off+i]};
            for (int b = 0; b < 8; b++) s = s[0] ? ((s >> 1) ^ p) : (s >> 1);
        end
        return ~s;
    endfunction

    task automatic do_start(input logic [31:0] seed, input bit sel);
        @(negedge clk);
        start_i = 1'b1; seed_i = seed; poly_sel_i = sel;
        @(negedge clk);
        start_i = 1'b0;
        check(in_ready_o == 1'b1, "R2 ready after start", {31'h0, in_ready_o}, 32'h1);
    endtask

    // Drive one beat at a falling edge. For a last beat, sample at the next falling edge.
    task automatic send_beat(input logic [31:0] data, input int cnt, input bit last,
                             output bit done_seen, output logic [31:0] got);
        @(negedge clk);
        in_valid_i = 1'b1; in_data_i = data; in_count_i = cnt[2:0]; in_last_i = last;
        @(negedge clk);
        done_seen = done_o; got = crc_o;
        in_valid_i = 1'b0; in_last_i = $urandom_range(0, 1); in_data_i = $urandom;
    endtask

    task automatic run_msg(input logic [31:0] seed, input bit sel, input int off, input int n,
                           input bit rnd, output logic [31:0] got);
        int idx = 0;
        bit dn = 1'b0;
        do_start(seed, sel);
        if (n == 0) begin
            send_beat($urandom, 0, 1'b1, dn, got);
        end else begin
            while (idx < n) begin
                int cnt = rnd ? int'($urandom_range(1, 4)) : 4;
                logic [31:0] d = $urandom;
                if (cnt > n - idx) cnt = n - idx;
                for (int k = 0; k < cnt; k++) d[8*k +: 8] = msg[off+idx+k];
                if (rnd) repeat ($urandom_range(0, 2)) @(negedge clk);
                send_beat(d, cnt, (idx + cnt == n), dn, got);
                idx += cnt;
            end
        end
        check(dn == 1'b1, "R10 done after last beat", {31'h0, dn}, 32'h1);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        logic [31:0] r, r2, held;
        bit dn;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 during and after reset
        check(in_ready_o == 0 && done_o == 0 && crc_o == 0, "R1 reset state", crc_o, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready_o == 0 && done_o == 0 && crc_o == 0, "R1 after release", crc_o, 32'h0);

        // R9 empty message
        run_msg(32'h0, 1'b0, 0, 0, 1'b0, r);
        check(r == 32'h0, "R9 empty message", r, 32'h0);

        // R3 check vector as one beat with junk in the top lane (R5)
        msg[0] = 8'h48; msg[1] = 8'h69; msg[2] = 8'h0A;
        do_start(32'h0, 1'b0);
        send_beat(32'hA50A6948, 3, 1'b1, dn, r);
        check(r == 32'hD5223C9A, "R3 R5 one beat with junk lane", r, 32'hD5223C9A);
        // R10 hold and closed input
        @(negedge clk);
        check(done_o == 0, "R10 strobe one cycle", {31'h0, done_o}, 32'h0);
        check(in_ready_o == 0, "R10 ready low after finish", {31'h0, in_ready_o}, 32'h0);
        // R11 a beat offered while not ready is ignored
        send_beat(32'h12345678, 4, 1'b1, dn, r2);
        check(!dn && r2 == 32'hD5223C9A, "R11 beat while idle ignored", r2, 32'hD5223C9A);

        // R3 bytewise
        do_start(32'h0, 1'b0);
        send_beat(32'hFFFFFF48, 1, 1'b0, dn, r);
        send_beat(32'hFFFFFF69, 1, 1'b0, dn, r);
        send_beat(32'hFFFFFF0A, 1, 1'b1, dn, r);
        check(r == 32'hD5223C9A, "R3 bytewise", r, 32'hD5223C9A);

        // R4 digits under both polynomials
        for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
        run_msg(32'h0, 1'b1, 0, 9, 1'b0, r);
        check(r == 32'hE3069283, "R4 Castagnoli digits", r, 32'hE3069283);
        run_msg(32'h0, 1'b0, 0, 9, 1'b1, r);
        check(r == 32'hCBF43926, "R4 IEEE digits", r, 32'hCBF43926);
        held = r;

        // R11 a count-0 middle beat and valid-low cycles do not disturb the state
        do_start(32'h0, 1'b0);
        send_beat(32'h34333231, 4, 1'b0, dn, r);
        send_beat(32'hDEADBEEF, 0, 1'b0, dn, r);
        send_beat(32'h38373635, 4, 1'b0, dn, r);
        send_beat(32'h00000039, 1, 1'b1, dn, r);
        check(r == held, "R9 R11 count-0 beat absorbs nothing", r, held);

        // R8 leading zero byte
        msg[0] = 8'h00; msg[1] = 8'h48; msg[2] = 8'h69; msg[3] = 8'h0A;
        run_msg(32'h0, 1'b0, 0, 4, 1'b0, r);
        check(r != 32'hD5223C9A && r == ref_crc(32'h0, 1'b0, 0, 4), "R8 leading zero changes result", r, ref_crc(32'h0, 1'b0, 0, 4));

        // R7 resume: s = msg[0..10], t = msg[11..30]
        for (int i = 0; i < 31; i++) msg[i] = 8'($urandom);
        for (int p = 0; p < 2; p++) begin
            run_msg(32'h0, p[0], 0, 11, 1'b1, r);
            run_msg(r, p[0], 11, 20, 1'b1, r2);
            check(r2 == ref_crc(32'h0, p[0], 0, 31), "R7 resume equals one pass", r2, ref_crc(32'h0, p[0], 0, 31));
        end

        // R6 random lengths, splits, gaps, seeds and polynomials
        for (int t = 0; t < 40; t++) begin
            int n = $urandom_range(0, 40);
            bit sel = $urandom_range(0, 1);
            logic [31:0] sd = (t % 3 == 0) ? 32'h0 : $urandom;
            for (int i = 0; i < n; i++) msg[i] = 8'($urandom);
            run_msg(sd, sel, 0, n, 1'b1, r);
            check(r == ref_crc(sd, sel, 0, n), "R6 random split", r, ref_crc(sd, sel, 0, n));
        end

        // R2 start priority over a same-cycle beat
        @(negedge clk);
        start_i = 1'b1; seed_i = 32'h0; poly_sel_i = 1'b0;
        in_valid_i = 1'b1; in_data_i = 32'h11111111; in_count_i = 3'd4; in_last_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0; in_valid_i = 1'b0;
        send_beat(32'h000A6948, 3, 1'b1, dn, r);
        check(r == 32'hD5223C9A, "R2 start wins over beat", r, 32'hD5223C9A);

        finish_run();
    end
endmodule